// File: doc/BRIEF.md
# One-Time-Programmable Byte ROM Emulator

This block is a clocked stand-in for an 8192-word, 8-bit-wide read-only program store whose cells can be programmed once. It drops in wherever a byte-wide program memory with separate select and output-gate lines is expected. Every access, programming pulse and mode choice happens on clock edges. Access latency is counted in cycles instead of nanoseconds. Two level inputs, `vpp_hi` and `id_hi`, stand in for the raised programming supply and the elevated identifier level.

The mode state machine has these states: `MD_INIT`, `MD_STANDBY`, `MD_OUT_OFF`, `MD_READ`, `MD_IDENT`, `MD_PROGRAM`, `MD_VERIFY` and `MD_INHIBIT`.

- Reset enters `MD_INIT`. The block stays there for one edge per cell while it fills the array with FFh.
- On the edge that writes the last cell, `MD_INIT` leaves for the decoded mode.
- From any other state, each edge moves to the mode decoded from `ce_n`, `oe_n`, `vpp_hi` and `id_hi` as sampled on that edge.
- The decode applies these rules in order:
  1. With `ce_n` high, the next state is `MD_INHIBIT` if `vpp_hi` is set, and `MD_STANDBY` otherwise.
  2. With `ce_n` low and `vpp_hi` set, `oe_n` chooses `MD_PROGRAM` (high) or `MD_VERIFY` (low).
  3. Without `vpp_hi`, a high `oe_n` gives `MD_OUT_OFF`.
  4. Without `vpp_hi`, a low `oe_n` gives `MD_IDENT` when `id_hi` is set, and `MD_READ` otherwise.

Top module: `otp_rom_emu`

## Requirements
- R1: After reset is released, the first 8192 clock edges write FFh into every cell. During these edges `dout_en` stays 0 and program strobes change nothing.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hi`=0, once the latencies are met, `dout_en`=1 and `dout` is the stored byte at the sampled address.
- R3: An edge that samples `ce_n`=1 leaves `dout_en`=0 and `dout`=00h afterwards, whatever `oe_n` is.
- R4: An edge that samples `ce_n`=0 with `oe_n`=1 and `vpp_hi`=0 leaves `dout_en`=0 and `dout`=00h.
- R5: With `id_hi`=1, `vpp_hi`=0 and a read selected, `dout` is 9Bh when address bit 0 is 0 and 08h when it is 1. The array is not read in this case.
- R6: A write needs `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, plus a program strobe that goes low. The write leaves the cell at its old value AND `din`, so bits can only go from 1 to 0.
- R7: Each low strobe pulse writes exactly once. The write happens at the first edge that samples `pgm_n`=0 after it was sampled 1. Later edges of the same pulse write nothing, even if `din` changes.
- R8: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=0, the stored byte at the address is driven, with the same latencies as a read.
- R9: With `vpp_hi`=1 and `ce_n`=1, strobes change no cell and `dout_en` is 0.
- R10: Data becomes valid at the ACC_LAT-th edge (default 3), counting from the first edge that samples a new address or `ce_n` low. Any change of address restarts this count.
- R11: Data becomes valid at the OE_LAT-th edge (default 1), counting from the first edge that samples `oe_n` low.
- R12: With `vpp_hi`=1, a strobe pulse that arrives while `oe_n` is low changes no cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Word address |
| din | input | 8 | Byte to program |
| ce_n | input | 1 | Active-low chip select (power control) |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised |
| id_hi | input | 1 | Identifier level raised |
| dout | output | 8 | Read data, 00h when not driven |
| dout_en | output | 1 | Tri-state enable for `dout` |

## Verification
The bench holds `pgm_n` low across several edges while `din` changes. A design that wrote on level instead of on the falling edge would clear more bits than the first byte allows. The bench pulses the strobe in verify mode and again while deselected with the supply raised. It then reads the cell back to expose any write that leaked through. The bench changes the address during a settled read, to catch a latency counter that only restarts on chip select. The identifier is read at an address whose stored byte was changed, so a design that returned array data instead of the fixed bytes would show the wrong value.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

    typedef enum logic [2:0] {
        MD_INIT    = 3'd0,
        MD_STANDBY = 3'd1,
        MD_OUT_OFF = 3'd2,
        MD_READ    = 3'd3,
        MD_IDENT   = 3'd4,
        MD_PROGRAM = 3'd5,
        MD_VERIFY  = 3'd6,
        MD_INHIBIT = 3'd7
    } rom_mode_e;

    localparam logic [7:0] ID_MAKER = 8'h9B;
    localparam logic [7:0] ID_PART  = 8'h08;

    // Mode selected by one set of sampled control levels.
    function automatic rom_mode_e decode_mode(
        input logic ce_n,
        input logic oe_n,
        input logic vpp_hi,
        input logic id_hi
    );
        rom_mode_e m;
        if (ce_n)        m = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (vpp_hi) m = oe_n   ? MD_PROGRAM : MD_VERIFY;
        else if (oe_n)   m = MD_OUT_OFF;
        else             m = id_hi  ? MD_IDENT   : MD_READ;
        return m;
    endfunction

endpackage

// File: rtl/otp_mode_fsm.sv
module otp_mode_fsm
    import otp_rom_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    output rom_mode_e         state,
    output logic              init_busy,
    output logic [ADDR_W-1:0] init_addr
);

    localparam logic [ADDR_W-1:0] LAST_CELL = {ADDR_W{1'b1}};

    rom_mode_e         state_nx;
    rom_mode_e         sel_mode;
    logic [ADDR_W-1:0] fill_ptr;

    assign sel_mode = decode_mode(ce_n, oe_n, vpp_hi, id_hi);

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            MD_INIT:    state_nx = (fill_ptr == LAST_CELL) ? sel_mode : MD_INIT;
            MD_STANDBY,
            MD_OUT_OFF,
            MD_READ,
            MD_IDENT,
            MD_PROGRAM,
            MD_VERIFY,
            MD_INHIBIT: state_nx = sel_mode;
        endcase
    end

    // State register and fill pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= MD_INIT;
            fill_ptr <= '0;
        end else begin
            state <= state_nx;
            if (state == MD_INIT) fill_ptr <= fill_ptr + 1'b1;
        end
    end

    // Outputs of the state machine
    always_comb begin
        init_busy = 1'b0;
        init_addr = fill_ptr;
        unique case (state)
            MD_INIT:    init_busy = 1'b1;
            MD_STANDBY,
            MD_OUT_OFF,
            MD_READ,
            MD_IDENT,
            MD_PROGRAM,
            MD_VERIFY,
            MD_INHIBIT: init_busy = 1'b0;
        endcase
    end

    AST_INIT_NEVER_REENTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MD_INIT) |=> (state != MD_INIT)); // R1

endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
    parameter int ADDR_W  = 13,
    parameter int ACC_LAT = 3,
    parameter int OE_LAT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_held,
    output logic              acc_ok,
    output logic              oe_ok
);

    localparam int ACC_W = (ACC_LAT < 1) ? 1 : $clog2(ACC_LAT + 1);
    localparam int OE_W  = (OE_LAT  < 1) ? 1 : $clog2(OE_LAT + 1);
    localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(ACC_LAT);
    localparam logic [OE_W-1:0]  OE_TOP  = OE_W'(OE_LAT);

    logic [ACC_W-1:0]  acc_cnt;
    logic [OE_W-1:0]   oe_cnt;
    logic [ADDR_W-1:0] addr_q;

    // Address / select latency: restarts on deselect or any address change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            addr_q  <= '0;
        end else begin
            addr_q <= addr;
            if (clr || ce_n)           acc_cnt <= '0;
            else if (addr != addr_q)   acc_cnt <= ACC_W'(1);
            else if (acc_cnt != ACC_TOP) acc_cnt <= acc_cnt + 1'b1;
        end
    end

    // Output-gate latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_cnt <= '0;
        end else if (clr || oe_n) begin
            oe_cnt <= '0;
        end else if (oe_cnt != OE_TOP) begin
            oe_cnt <= oe_cnt + 1'b1;
        end
    end

    assign addr_held = addr_q;
    assign acc_ok    = (acc_cnt == ACC_TOP);
    assign oe_ok     = (oe_cnt == OE_TOP);

    AST_ACC_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> !$past(ce_n)); // R10
    AST_OE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ok |-> !$past(oe_n)); // R11

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // One write port shared by the reset fill and programming; a
    // programming write can only clear bits.
    always_ff @(posedge clk) begin
        if (fill_we)      cells[fill_addr] <= {DATA_W{1'b1}};
        else if (prog_we) cells[addr]      <= cells[addr] & din;
        rd_q <= cells[addr];
    end

    assign rd_data = rd_q;

    always_comb begin
        AST_FILL_PROG_EXCLUSIVE: assert (!(fill_we && prog_we)); // R1
    end

endmodule

// File: rtl/otp_rom_emu.sv
module otp_rom_emu
    import otp_rom_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int ACC_LAT = 3,
    parameter int OE_LAT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    rom_mode_e         state;
    logic              init_busy;
    logic [ADDR_W-1:0] init_addr;
    logic [ADDR_W-1:0] addr_held;
    logic              acc_ok;
    logic              oe_ok;
    logic [DATA_W-1:0] rd_data;
    logic              pgm_q;
    logic              strobe_fall;
    logic              prog_we;
    rom_mode_e         live_mode;

    otp_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_hi    (vpp_hi),
        .id_hi     (id_hi),
        .state     (state),
        .init_busy (init_busy),
        .init_addr (init_addr)
    );

    otp_access_timer #(
        .ADDR_W  (ADDR_W),
        .ACC_LAT (ACC_LAT),
        .OE_LAT  (OE_LAT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (init_busy),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .addr_held (addr_held),
        .acc_ok    (acc_ok),
        .oe_ok     (oe_ok)
    );

    otp_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk       (clk),
        .fill_we   (init_busy),
        .fill_addr (init_addr),
        .prog_we   (prog_we),
        .addr      (addr),
        .din       (din),
        .rd_data   (rd_data)
    );

    // Strobe edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pgm_q <= 1'b1;
        else        pgm_q <= pgm_n;
    end

    assign strobe_fall = pgm_q && !pgm_n;
    assign live_mode   = decode_mode(ce_n, oe_n, vpp_hi, id_hi);
    assign prog_we     = !init_busy && (live_mode == MD_PROGRAM) && strobe_fall;

    // Output process driven by the registered mode
    always_comb begin
        dout_en = 1'b0;
        dout    = '0;
        unique case (state)
            MD_READ, MD_VERIFY: begin
                dout_en = acc_ok && oe_ok;
                dout    = dout_en ? rd_data : '0;
            end
            MD_IDENT: begin
                dout_en = acc_ok && oe_ok;
                if (dout_en) dout = addr_held[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER);
            end
            MD_INIT, MD_STANDBY, MD_OUT_OFF, MD_PROGRAM, MD_INHIBIT: begin
                dout_en = 1'b0;
                dout    = '0;
            end
        endcase
    end

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dout_en); // R3
    AST_GATE_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && oe_n) |-> !dout_en); // R4
    AST_ID_FIXED_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && state == MD_IDENT) |-> (dout == DATA_W'(ID_MAKER) || dout == DATA_W'(ID_PART))); // R5
    AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> !prog_we); // R7
    AST_NO_WRITE_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> oe_n); // R12
    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> !ce_n); // R9

endmodule

// File: tb/otp_rom_emu_bench.sv
module otp_rom_emu_bench;

    localparam int AW    = 13;
    localparam int DEPTH = 1 << AW;
    localparam int ACC   = 3;
    localparam int OEL   = 1;

    localparam int K_INIT = 0, K_STBY = 1, K_OFF = 2, K_READ = 3,
                   K_ID = 4, K_PROG = 5, K_VER = 6, K_INH = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
    logic [7:0]    dout;
    logic          dout_en;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    otp_rom_emu u_otp_rom_emu (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
        .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi), .id_hi(id_hi),
        .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk; // 50 MHz

    // Behavioural reference model
    logic [7:0]    m [DEPTH];
    int            m_mode, m_acc, m_oe, m_fill;
    logic          m_pq;
    logic [AW-1:0] m_aq;
    logic [7:0]    m_rd;

    function automatic int pick(logic c, logic o, logic v, logic i);
        if (c) return v ? K_INH : K_STBY;
        if (v) return o ? K_PROG : K_VER;
        if (o) return K_OFF;
        return i ? K_ID : K_READ;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = K_INIT; m_acc = 0; m_oe = 0; m_fill = 0;
            m_pq = 1'b1; m_aq = '0; m_rd = 8'h00;
        end else begin
            int d;
            d = pick(ce_n, oe_n, vpp_hi, id_hi);
            if (m_mode == K_INIT) begin
                m[m_fill] = 8'hFF;
                m_acc = 0; m_oe = 0;
                if (m_fill == DEPTH - 1) m_mode = d;
                m_fill++;
            end else begin
                m_rd = m[addr];
                if (d == K_PROG && !pgm_n && m_pq) m[addr] = m[addr] & din;
                if (ce_n)             m_acc = 0;
                else if (addr != m_aq) m_acc = 1;
                else if (m_acc < ACC)  m_acc++;
                if (oe_n)            m_oe = 0;
                else if (m_oe < OEL) m_oe++;
                m_mode = d;
            end
            m_pq = pgm_n; m_aq = addr;
        end
    end

    function automatic logic exp_en();
        return (m_mode == K_READ || m_mode == K_ID || m_mode == K_VER) && m_acc >= ACC && m_oe >= OEL;
    endfunction

    function automatic logic [7:0] exp_dout();
        if (!exp_en()) return 8'h00;
        if (m_mode == K_ID) return m_aq[0] ? 8'h08 : 8'h9B;
        return m_rd;
    endfunction

    // Every-clock comparison, 5 ns after the rising edge
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            checks++;
            if (dout_en !== exp_en() || dout !== exp_dout()) begin
                fails++;
                $display("FAIL %s: en/dout actual %0b/%02h expected %0b/%02h", cur_req,
                         dout_en, dout, exp_en(), exp_dout());
            end
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #6;
        end
    endtask

    task automatic expect_out(logic en, logic [7:0] d, string tag);
        checks++;
        if (dout_en !== en || dout !== d) begin
            fails++;
            $display("FAIL %s: en/dout actual %0b/%02h expected %0b/%02h", tag, dout_en, dout, en, d);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 60000; i++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        report();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1: strobe attempt during fill must not stick
        cur_req = "R1";
        vpp_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b1; addr = 13'd20; din = 8'h00;
        cyc(2); pgm_n = 1'b0; cyc(2); pgm_n = 1'b1;
        cyc(DEPTH);
        expect_out(1'b0, 8'h00, "R1");
        vpp_hi = 1'b0; ce_n = 1'b1; cyc(2);

        // R3: standby with gate open
        cur_req = "R3";
        oe_n = 1'b0; cyc(4);
        expect_out(1'b0, 8'h00, "R3");

        // R2/R10: read an erased cell, latency 3 from select
        cur_req = "R10";
        ce_n = 1'b0; addr = 13'd20; cyc(2);
        expect_out(1'b0, 8'h00, "R10");
        cyc(1);
        expect_out(1'b1, 8'hFF, "R2");

        // R4: output disable
        cur_req = "R4";
        oe_n = 1'b1; cyc(1);
        expect_out(1'b0, 8'h00, "R4");
        // R11: gate reopens, one cycle
        cur_req = "R11";
        oe_n = 1'b0; cyc(1);
        expect_out(1'b1, 8'hFF, "R11");

        // R6/R8: program and verify
        cur_req = "R6";
        addr = 13'd5; vpp_hi = 1'b1; oe_n = 1'b1; din = 8'hA5; cyc(4);
        pgm_n = 1'b0; cyc(1); pgm_n = 1'b1; cyc(1);
        cur_req = "R8";
        oe_n = 1'b0; cyc(1);
        expect_out(1'b1, 8'hA5, "R8");
        cur_req = "R6";
        oe_n = 1'b1; din = 8'h0F; cyc(1);
        pgm_n = 1'b0; cyc(1); pgm_n = 1'b1; oe_n = 1'b0; cyc(1);
        expect_out(1'b1, 8'h05, "R6");

        // R12: strobe in verify mode ignored
        cur_req = "R12";
        din = 8'h00; pgm_n = 1'b0; cyc(2); pgm_n = 1'b1; cyc(2);
        expect_out(1'b1, 8'h05, "R12");

        // R9: inhibit
        cur_req = "R9";
        ce_n = 1'b1; oe_n = 1'b1; cyc(1);
        pgm_n = 1'b0; cyc(1);
        expect_out(1'b0, 8'h00, "R9");
        pgm_n = 1'b1; vpp_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b0; cyc(3);
        expect_out(1'b1, 8'h05, "R9");

        // R7: long pulse with changing data writes once
        cur_req = "R7";
        addr = 13'd10; vpp_hi = 1'b1; oe_n = 1'b1; din = 8'hF0; cyc(1);
        pgm_n = 1'b0; cyc(1); din = 8'h00; cyc(3); pgm_n = 1'b1; cyc(1);
        vpp_hi = 1'b0; oe_n = 1'b0; cyc(3);
        expect_out(1'b1, 8'hF0, "R7");

        // R10: address change restarts count
        cur_req = "R10";
        addr = 13'd5; cyc(1);
        expect_out(1'b0, 8'h00, "R10");
        cyc(1);
        expect_out(1'b0, 8'h00, "R10");
        cyc(1);
        expect_out(1'b1, 8'h05, "R10");

        // R6: top cell
        cur_req = "R6";
        addr = 13'h1FFF; vpp_hi = 1'b1; oe_n = 1'b1; din = 8'h3C; cyc(1);
        pgm_n = 1'b0; cyc(1); pgm_n = 1'b1; vpp_hi = 1'b0; oe_n = 1'b0; cyc(3);
        expect_out(1'b1, 8'h3C, "R6");

        // R5: identifier bytes
        cur_req = "R5";
        id_hi = 1'b1; addr = 13'd0; cyc(3);
        expect_out(1'b1, 8'h9B, "R5");
        addr = 13'd1; cyc(3);
        expect_out(1'b1, 8'h08, "R5");
        addr = 13'd10; cyc(3);
        expect_out(1'b1, 8'h9B, "R5");
        addr = 13'd5; cyc(3);
        expect_out(1'b1, 8'h08, "R5");
        id_hi = 1'b0; cyc(1);
        expect_out(1'b1, 8'h05, "R2");

        cur_req = "R3";
        ce_n = 1'b1; cyc(2);
        expect_out(1'b0, 8'h00, "R3");
        report();
    end

endmodule